// File: doc/BRIEF.md
# VGA Packed-Byte Frame Sequencer

This block walks the horizontal and vertical timing of a 640x480 raster and emits one 8-bit word per pixel clock. Each word carries both active-low sync levels and a 6-bit colour, so the output can be replayed unchanged from a byte-wide memory or fed straight to a resistor DAC. The horizontal and vertical phases run in a fixed order. Colour is held at zero in every blanking interval. During visible pixels the block takes colour from an upstream source through a ready/valid handshake.

A scan line opens with its front porch, followed by the sync pulse, the back porch and then the visible pixels. A frame opens with its vertical back porch, followed by the visible lines, the vertical front porch and then the vertical sync lines. The output word is registered. Both sync bits and the colour bits therefore change on the same clock edge. A one-cycle marker flags the first word of every frame. All phase lengths are parameters, with defaults for the 640x480 mode.

Top module: `vga_frame_seq`

## Requirements
- R1: The output word holds vertical sync in bit 7, horizontal sync in bit 6, red in bits 5:4, green in bits 3:2 and blue in bits 1:0. An accepted pixel value appears unchanged in bits 5:0.
- R2: A line of 800 cycles is 16 front-porch cycles, then 96 horizontal-sync cycles, then 48 back-porch cycles, then 640 visible cycles. The line then wraps to its front porch.
- R3: A frame of 525 lines is 33 back-porch lines, then 480 visible lines, then 10 front-porch lines, then 2 vertical-sync lines. The line count advances only as a line wraps.
- R4: Both sync bits are active low. Each is 1 outside its own sync phase and 0 throughout that phase.
- R5: Colour bits are 0 in every porch cycle, every sync cycle and every vertical blanking line.
- R6: Horizontal sync keeps its per-line pattern on every vertical blanking line, including the vertical-sync lines.
- R7: pixel_ready is high exactly in visible cycles, meaning a visible column on a visible line. A visible cycle with pixel_valid high uses pixel_data. A visible cycle with pixel_valid low outputs colour 0.
- R8: While synchronous reset is high, the output word is 8'hC0, frame_start is 0 and pixel_ready is 0. The first word after reset is the first cycle of the first vertical back-porch line.
- R9: frame_start is high for exactly the one cycle in which the first word of a frame (value 8'hC0) is on the output.
- R10: The pixel accepted at a clock edge and the sync levels for that position both appear in the word registered at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pixel_valid | input | 1 | Upstream colour is valid |
| pixel_data | input | 6 | Upstream colour, red 5:4, green 3:2, blue 1:0 |
| pixel_ready | output | 1 | Block accepts a colour this cycle (visible cycle) |
| vga_word | output | 8 | Packed vertical sync, horizontal sync and colour |
| frame_start | output | 1 | High with the first word of each frame |

## Verification
Assertions check every cycle that each counter either steps by one, wraps to its first position or holds. They also check that a low sync bit always follows a cycle inside that sync window, that nonzero colour always follows an accepted handshake, and that ready never overlaps a sync phase. Only the bench's scenarios can show the exact phase lengths and their order. The bench compares every output word against an independent position model, using a fast-timing instance that covers many whole frames and the default 640x480 instance that covers the first visible lines. The reset state and the first-word marker after a mid-frame reset are also shown only by the bench.

// File: rtl/vga_seq_pkg.sv
package vga_seq_pkg;
  localparam int CLR_W  = 6;
  localparam int WORD_W = CLR_W + 2;

  typedef logic [CLR_W-1:0]  colour_t;
  typedef logic [WORD_W-1:0] word_t;

  // idle word: both syncs released, colour black
  localparam word_t IDLE_WORD = {2'b11, {CLR_W{1'b0}}};

  // true when pos lies in [lo, lo+len)
  function automatic logic in_window(int unsigned pos, int unsigned lo, int unsigned len);
    return (pos >= lo) && (pos < lo + len);
  endfunction

  // sync levels in the two top bits, colour below
  function automatic word_t pack_word(logic vs_n, logic hs_n, colour_t c);
    return {vs_n, hs_n, c};
  endfunction
endpackage

// File: rtl/vga_phase_counter.sv
module vga_phase_counter
  import vga_seq_pkg::*;
#(
  parameter int  BLANK_A   = 16,
  parameter int  SYNC_LEN  = 96,
  parameter int  BLANK_B   = 48,
  parameter int  SHOW_LEN  = 640,
  parameter bit  SYNC_LAST = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic at_first,
  output logic at_last,
  output logic in_sync,
  output logic in_show
);
  localparam int TOTAL = BLANK_A + SYNC_LEN + BLANK_B + SHOW_LEN;
  localparam int W     = $clog2(TOTAL);
  localparam logic [W-1:0] LAST = W'(TOTAL - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= at_last ? '0 : cnt + W'(1);
  end

  assign at_first = (cnt == '0);
  assign at_last  = (cnt == LAST);

  generate
    if (SYNC_LAST) begin : g_frame_order
      // blank A, visible, blank B, sync
      assign in_show = in_window(32'(cnt), BLANK_A, SHOW_LEN);
      assign in_sync = in_window(32'(cnt), BLANK_A + SHOW_LEN + BLANK_B, SYNC_LEN);
    end else begin : g_line_order
      // blank A, sync, blank B, visible
      assign in_sync = in_window(32'(cnt), BLANK_A, SYNC_LEN);
      assign in_show = in_window(32'(cnt), BLANK_A + SYNC_LEN + BLANK_B, SHOW_LEN);
    end
  endgenerate

  a_r2_wrap_to_first: assert property (@(posedge clk) disable iff (rst)
    (step && at_last) |=> at_first);
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (rst)
    (step && !at_last) |=> (cnt == $past(cnt) + W'(1)));
  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(cnt));
endmodule

// File: rtl/vga_word_packer.sv
module vga_word_packer
  import vga_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    hs_on,
  input  logic    vs_on,
  input  logic    take,
  input  colour_t colour,
  input  logic    first,
  output word_t   word,
  output logic    frame_start
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word        <= IDLE_WORD;
      frame_start <= 1'b0;
    end else begin
      word        <= pack_word(!vs_on, !hs_on, take ? colour : '0);
      frame_start <= first;
    end
  end

  a_r5_black_unless_taken: assert property (@(posedge clk) disable iff (rst)
    (word[CLR_W-1:0] != '0) |-> $past(take));
endmodule

// File: rtl/vga_frame_seq.sv
module vga_frame_seq
  import vga_seq_pkg::*;
#(
  parameter int H_FRONT  = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BACK   = 48,
  parameter int H_ACTIVE = 640,
  parameter int V_BACK   = 33,
  parameter int V_ACTIVE = 480,
  parameter int V_FRONT  = 10,
  parameter int V_SYNC   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pixel_valid,
  input  logic [5:0] pixel_data,
  output logic       pixel_ready,
  output logic [7:0] vga_word,
  output logic       frame_start
);
  // named internal events for the assertions
  logic h_first, h_last, h_sync, h_show;
  logic v_first, v_last, v_sync, v_show;
  logic take, first_pos;

  vga_phase_counter #(
    .BLANK_A(H_FRONT), .SYNC_LEN(H_SYNC), .BLANK_B(H_BACK),
    .SHOW_LEN(H_ACTIVE), .SYNC_LAST(1'b0)
  ) u_line (
    .clk(clk), .rst(rst), .step(1'b1),
    .at_first(h_first), .at_last(h_last), .in_sync(h_sync), .in_show(h_show)
  );

  vga_phase_counter #(
    .BLANK_A(V_BACK), .SYNC_LEN(V_SYNC), .BLANK_B(V_FRONT),
    .SHOW_LEN(V_ACTIVE), .SYNC_LAST(1'b1)
  ) u_frame (
    .clk(clk), .rst(rst), .step(h_last),
    .at_first(v_first), .at_last(v_last), .in_sync(v_sync), .in_show(v_show)
  );

  assign pixel_ready = h_show && v_show && !rst;
  assign take        = pixel_ready && pixel_valid;
  assign first_pos   = h_first && v_first;

  vga_word_packer u_pack (
    .clk(clk), .rst(rst),
    .hs_on(h_sync), .vs_on(v_sync),
    .take(take), .colour(pixel_data), .first(first_pos),
    .word(vga_word), .frame_start(frame_start)
  );

  a_r4_hsync_low_in_window: assert property (@(posedge clk) disable iff (rst)
    !vga_word[6] |-> $past(h_sync));
  a_r4_vsync_low_in_window: assert property (@(posedge clk) disable iff (rst)
    !vga_word[7] |-> $past(v_sync));
  a_r7_ready_outside_sync: assert property (@(posedge clk) disable iff (rst)
    pixel_ready |-> (!h_sync && !v_sync));
  a_r9_marker_word: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (vga_word == 8'hC0) && $past(first_pos));
  a_r3_frame_wrap: assert property (@(posedge clk) disable iff (rst)
    (h_last && v_last) |=> first_pos);
endmodule

// File: tb/tb_vga_frame_seq.sv
module tb_vga_frame_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixel_valid = 1'b0;
  logic [5:0] pixel_data = '0;
  logic rdy_d, fs_d, rdy_s, fs_s;
  logic [7:0] word_d, word_s;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  // default 640x480 timing
  vga_frame_seq dut (
    .clk(clk), .rst(rst), .pixel_valid(pixel_valid), .pixel_data(pixel_data),
    .pixel_ready(rdy_d), .vga_word(word_d), .frame_start(fs_d));

  // shrunk timing so whole frames fit the run: line 4/6/3/10, frame 3/5/2/2
  vga_frame_seq #(.H_FRONT(4), .H_SYNC(6), .H_BACK(3), .H_ACTIVE(10),
                  .V_BACK(3), .V_ACTIVE(5), .V_FRONT(2), .V_SYNC(2)) dut_small (
    .clk(clk), .rst(rst), .pixel_valid(pixel_valid), .pixel_data(pixel_data),
    .pixel_ready(rdy_s), .vga_word(word_s), .frame_start(fs_s));

  typedef struct packed {
    int unsigned pos;
    logic hs; logic vs; logic act;
  } vec_t;

  // boundary vectors for the default instance (position since reset release)
  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{0,     1'b1, 1'b1, 1'b0}, '{15,    1'b1, 1'b1, 1'b0},
    '{16,    1'b0, 1'b1, 1'b0}, '{111,   1'b0, 1'b1, 1'b0},
    '{112,   1'b1, 1'b1, 1'b0}, '{159,   1'b1, 1'b1, 1'b0},
    '{160,   1'b1, 1'b1, 1'b0}, '{799,   1'b1, 1'b1, 1'b0},
    '{816,   1'b0, 1'b1, 1'b0}, '{26559, 1'b1, 1'b1, 1'b0},
    '{26560, 1'b1, 1'b1, 1'b1}, '{27199, 1'b1, 1'b1, 1'b1},
    '{27200, 1'b1, 1'b1, 1'b0}};

  function automatic logic src_valid(int pos);
    return (pos % 7) != 3;
  endfunction
  function automatic logic [5:0] src_data(int pos);
    return {1'b1, 5'(pos)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // independent position model: hf,hs,hb,ha / vb,va,vf,vs
  task automatic model(input int pos, input int hf, input int hs, input int hb, input int ha,
                       input int vb, input int va, input int vf, input int vs,
                       output logic e_hs, output logic e_vs, output logic e_act,
                       output logic e_first);
    int ht = hf + hs + hb + ha;
    int vt = vb + va + vf + vs;
    int h = pos % ht;
    int v = (pos / ht) % vt;
    e_hs    = (h < hf) || (h >= hf + hs);
    e_vs    = v < (vt - vs);
    e_act   = (h >= ht - ha) && (v >= vb) && (v < vb + va);
    e_first = (pos % (ht * vt)) == 0;
  endtask

  task automatic check_word(input string who, input int pos, input logic [7:0] w, input logic fs,
                            input int hf, input int hs, input int hb, input int ha,
                            input int vb, input int va, input int vf, input int vs);
    logic e_hs, e_vs, e_act, e_first;
    logic [5:0] e_c;
    model(pos, hf, hs, hb, ha, vb, va, vf, vs, e_hs, e_vs, e_act, e_first);
    e_c = (e_act && src_valid(pos)) ? src_data(pos) : 6'd0;
    chk({who, " R2 R4 R6 hsync bit6"}, int'(w[6]), int'(e_hs));
    chk({who, " R3 R4 vsync bit7"}, int'(w[7]), int'(e_vs));
    chk({who, " R1 R5 R7 R10 colour"}, int'(w[5:0]), int'(e_c));
    chk({who, " R9 frame_start"}, int'(fs), int'(e_first));
  endtask

  task automatic check_ready(input string who, input int pos, input logic r,
                             input int hf, input int hs, input int hb, input int ha,
                             input int vb, input int va, input int vf, input int vs);
    logic e_hs, e_vs, e_act, e_first;
    model(pos, hf, hs, hb, ha, vb, va, vf, vs, e_hs, e_vs, e_act, e_first);
    chk({who, " R7 pixel_ready"}, int'(r), int'(e_act));
  endtask

  task automatic drive(input int pos);
    pixel_valid = src_valid(pos);
    pixel_data  = src_data(pos);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    int pos;
    int vi;
    repeat (3) @(negedge clk);
    // R8: state held in reset
    chk("R8 reset word dut", int'(word_d), 'hC0);
    chk("R8 reset frame_start dut", int'(fs_d), 0);
    chk("R8 reset ready dut", int'(rdy_d), 0);
    chk("R8 reset word small", int'(word_s), 'hC0);
    rst = 1'b0;
    pos = 0;
    vi = 0;
    drive(pos);
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      check_word("dut", pos, word_d, fs_d, 16, 96, 48, 640, 33, 480, 10, 2);
      check_word("small", pos, word_s, fs_s, 4, 6, 3, 10, 3, 5, 2, 2);
      if (vi < NVEC && VEC[vi].pos == pos) begin
        chk("R2 R4 vector hsync", int'(word_d[6]), int'(VEC[vi].hs));
        chk("R3 R4 vector vsync", int'(word_d[7]), int'(VEC[vi].vs));
        chk("R5 R7 vector colour", int'(word_d[5:0]),
            (VEC[vi].act && src_valid(pos)) ? int'(src_data(pos)) : 0);
        vi++;
      end
      pos++;
      check_ready("dut", pos, rdy_d, 16, 96, 48, 640, 33, 480, 10, 2);
      check_ready("small", pos, rdy_s, 4, 6, 3, 10, 3, 5, 2, 2);
      drive(pos);
    end
    chk("vector table walked", vi, NVEC);

    // R8 R9: reset in mid-frame, then restart from the first position
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid reset word", int'(word_s), 'hC0);
    chk("R8 mid reset frame_start", int'(fs_s), 0);
    chk("R8 mid reset ready", int'(rdy_d), 0);
    rst = 1'b0;
    drive(0);
    @(negedge clk);
    chk("R8 R9 first word after reset", int'(word_d), 'hC0);
    chk("R9 marker after reset", int'(fs_d), 1);
    drive(1);
    @(negedge clk);
    chk("R9 marker lasts one cycle", int'(fs_d), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end
endmodule